// File: doc/BRIEF.md
# Buffered serial port with software-loaded bit-rate divisor

This block is a memory-mapped asynchronous serial port with eight data bits, one stop bit and no parity. Software places characters into a 16-entry transmit queue through a write port and takes received characters from a 16-entry receive queue through a read port. A small register file holds control bits, a status word and the bit-rate setting. All registers are 32 bits wide and sit on a simple single-cycle select/write bus.

The bit period is the reference clock divided first by a fixed factor of three and then by a programmable 23-bit value plus one, so one serial bit lasts 3·(divisor+1) clock cycles. For a 24 MHz reference, software loads (24 000 000 / 3 / baud) − 1. The divisor only takes effect when the rate-enable bit of the bit-rate register is set. The bring-up sequence is fixed: software loads the bit-rate register, then pulses the two queue resets and the error-clear bit (set, then clear), and then sets the two enables. Transmit is polled through the status word: software writes while "TX full" is clear, and waits for "TX empty" to know that the line has gone quiet.

The receiver looks for a falling edge and re-checks the line half a bit later. It then samples each data bit in the middle of its period. A framing fault or a receive-queue overflow raises a sticky error flag.

Top module: `fifo_uart`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x0050_0000: bit 20 (RX empty) and bit 22 (TX empty) are set, bit 21 (TX full) and bit 16 (error) are clear. Control (0x08), bit-rate (0x14) and the RX port (0x04) read 0, and the serial output `txd` is high.
- R2: Control keeps only bits 24, 23, 22, 13 and 12, and the others read 0. The bit-rate register keeps bits 24:0 (divisor in 22:0, rate enable in 23, reference select in 24). The misc register at 0x10 always reads 0.
- R3: A write to offset 0x00 queues bits 7:0. When control bit 12 and bit-rate bit 23 are both set, queued bytes go out in order: a low start bit, data LSB first, then a high stop bit, each 3·(divisor+1) clocks long.
- R4: The TX queue holds 16 bytes. After 16 writes that do not drain, status bit 21 is set, and a 17th write is dropped.
- R5: Status bit 22 is set only when the TX queue is empty and no frame is being shifted out, including its stop bit.
- R6: With control bit 13 set, a frame on `rxd` is sampled at mid-bit and its byte is queued. A read of 0x04 returns the oldest byte in bits 7:0 and removes it. Status bit 20 is set when the queue is empty, and an RX read while empty returns 0.
- R7: A low pulse on `rxd` that no longer reads low half a bit period after its falling edge is not taken as a start bit.
- R8: A stop bit that reads 0 drops the byte and sets status bit 16. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: A byte that arrives while the RX queue holds 16 is dropped and sets status bit 16. Bit 16 stays set until control bit 24 is written 1, and it reads 0 on the cycle after that write.
- R10: While control bit 22 is set, the TX queue and transmitter are cleared (status bit 22 set, bit 21 clear). While control bit 23 is set, the RX queue is cleared (status bit 20 set).
- R11: While control bit 13 is clear, frames on `rxd` are ignored.
- R12: While bit-rate bit 23 is clear, no bit period elapses: `txd` holds its level and queued bytes wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |

## Verification
The assertions assume that software follows the bring-up order: the bit-rate register is stable while a frame is in flight, the reset bits are pulsed rather than left set, and nothing else drives the bus during the access cycle. They also assume that `rxd` changes only at clock granularity and keeps one bit period per bit. The stimulus keeps to these assumptions. Every register change is made between frames, `rxd` is driven on falling clock edges for whole multiples of the configured period, and random data is used only for byte values, never for timing. The one deliberate departure from a clean line is the short glitch used for R7.

// File: rtl/uart_pkg.sv
// Shared register offsets, bit positions and receiver state type for
// the buffered serial port. Assumes a 5-bit byte-offset bus address.
package uart_pkg;
    localparam logic [4:0] OFF_TXPORT = 5'h00;
    localparam logic [4:0] OFF_RXPORT = 5'h04;
    localparam logic [4:0] OFF_CTRL   = 5'h08;
    localparam logic [4:0] OFF_STAT   = 5'h0C;
    localparam logic [4:0] OFF_MISC   = 5'h10;
    localparam logic [4:0] OFF_RATE   = 5'h14;

    localparam int CTL_ERRCLR = 24;
    localparam int CTL_RXRST  = 23;
    localparam int CTL_TXRST  = 22;
    localparam int CTL_RXEN   = 13;
    localparam int CTL_TXEN   = 12;

    localparam int ST_ERR     = 16;
    localparam int ST_RXEMPTY = 20;
    localparam int ST_TXFULL  = 21;
    localparam int ST_TXEMPTY = 22;

    localparam int RATE_EN    = 23;
    localparam int RATE_XTAL  = 24;

    localparam logic [31:0] CTRL_KEEP = (32'd1 << CTL_ERRCLR) | (32'd1 << CTL_RXRST) |
                                        (32'd1 << CTL_TXRST)  | (32'd1 << CTL_RXEN)  |
                                        (32'd1 << CTL_TXEN);
    localparam logic [31:0] RATE_KEEP = 32'h01FF_FFFF;

    typedef enum logic [2:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP,
        RXS_WAITHI
    } rx_state_t;
endpackage

// File: rtl/uart_fifo.sv
// Synchronous queue with a synchronous clear. Pushes while full and pops
// while empty are ignored. Assumes DEPTH is a power of two, at least 2.
module uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/uart_bit_clock.sv
// Bit-period strobe: a fixed divide-by-PRE prescaler feeding a
// programmable divide-by-(divisor+1) counter. Produces one-cycle ticks
// every PRE*(divisor+1) clocks while run is high; holds in reset otherwise.
module uart_bit_clock #(
    parameter int DIV_W = 23,
    parameter int PRE   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam int PW = $clog2(PRE);

    logic [PW-1:0]    pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_last, div_last;

    assign pre_last = (pre_cnt == PW'(PRE - 1));
    assign div_last = (div_cnt >= divisor);
    assign tick     = run && pre_last && div_last;

    // Prescaler and divisor counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            div_cnt <= div_last ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
// Transmit shifter: takes a byte when enabled and idle, then emits start,
// eight data bits LSB first and stop, one bit per tick. Busy covers the
// whole stop bit. Assumes ticks are single-cycle strobes.
module uart_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       enable,
    input  logic       tick,
    input  logic       have_data,
    input  logic [7:0] data,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    logic [9:0] shreg;
    logic [3:0] nbits;

    assign pop = enable && !busy && have_data && !clr;

    // Frame load and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            txd   <= 1'b1;
            shreg <= '1;
            nbits <= '0;
        end else if (pop) begin
            busy  <= 1'b1;
            shreg <= {1'b1, data, 1'b0};
            nbits <= '0;
        end else if (busy && tick) begin
            if (nbits == 4'd10) begin
                busy <= 1'b0;
            end else begin
                txd   <= shreg[0];
                shreg <= {1'b1, shreg[9:1]};
                nbits <= nbits + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Receive framer: detects a falling edge, confirms the start bit at
// half a period, samples eight data bits and the stop bit at mid-bit.
// Emits a push pulse for a good frame or frame_err for a low stop bit.
// Assumes rxd_s is already synchronised and period is at least 2.
module uart_rx_frame #(
    parameter int PW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          enable,
    input  logic          rxd_s,
    input  logic [PW-1:0] period,
    output logic          push,
    output logic [7:0]    data,
    output logic          frame_err
);
    import uart_pkg::*;

    rx_state_t     state;
    logic [PW-1:0] cnt;
    logic [2:0]    nbit;
    logic [PW-1:0] half;
    logic          at_end;

    assign half   = period >> 1;
    assign at_end = (cnt == period - 1'b1);

    // Frame state machine with bit timing counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state     <= RXS_IDLE;
            cnt       <= '0;
            nbit      <= '0;
            data      <= '0;
            push      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            push      <= 1'b0;
            frame_err <= 1'b0;
            case (state)
                RXS_IDLE: begin
                    cnt <= '0;
                    if (enable && !rxd_s) state <= RXS_START;
                end
                RXS_START: begin
                    if (cnt == half) begin
                        cnt   <= '0;
                        nbit  <= '0;
                        state <= rxd_s ? RXS_IDLE : RXS_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_DATA: begin
                    if (at_end) begin
                        cnt  <= '0;
                        data <= {rxd_s, data[7:1]};
                        nbit <= nbit + 1'b1;
                        if (nbit == 3'd7) state <= RXS_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_STOP: begin
                    if (at_end) begin
                        cnt <= '0;
                        if (rxd_s) begin
                            push  <= 1'b1;
                            state <= RXS_IDLE;
                        end else begin
                            frame_err <= 1'b1;
                            state     <= RXS_WAITHI;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_WAITHI: begin
                    if (rxd_s) state <= RXS_IDLE;
                end
                default: state <= RXS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fifo_uart.sv
// Buffered serial port top: register file, transmit and receive queues,
// bit-rate generator, shifter and framer. Reads are combinational in the
// access cycle; an RX port read removes the head at the clock edge.
// Assumes software pulses the reset and error-clear bits.
module fifo_uart #(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd
);
    import uart_pkg::*;

    localparam int PER_W = DIV_W + 3;

    logic [31:0]      ctl_q, baud_q, status_w;
    logic             wr_en, rd_en;
    logic             tx_rst, rx_rst, err_clr, tx_en, rx_en, rate_on;
    logic [DIV_W-1:0] divisor;
    logic [PER_W-1:0] div_p1, period;
    logic             tx_push, tx_pop, tx_full, tx_fifo_empty, tx_busy, bit_tick;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic             rx_push, rx_pop, rx_full, rx_empty, rx_ferr;
    logic             rxd_m, rxd_s, err_q;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign tx_rst  = ctl_q[CTL_TXRST];
    assign rx_rst  = ctl_q[CTL_RXRST];
    assign err_clr = ctl_q[CTL_ERRCLR];
    assign tx_en   = ctl_q[CTL_TXEN];
    assign rx_en   = ctl_q[CTL_RXEN];
    assign rate_on = baud_q[RATE_EN];
    assign divisor = baud_q[DIV_W-1:0];
    assign div_p1  = PER_W'(divisor) + 1'b1;
    assign period  = div_p1 + (div_p1 << 1);
    assign tx_push = wr_en && (bus_addr == OFF_TXPORT);
    assign rx_pop  = rd_en && (bus_addr == OFF_RXPORT);

    // Control and bit-rate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            baud_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFF_CTRL) ctl_q  <= bus_wdata & CTRL_KEEP;
            if (bus_addr == OFF_RATE) baud_q <= bus_wdata & RATE_KEEP;
        end
    end

    // Two-flop synchroniser for the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    // Sticky error flag: framing fault or receive overflow; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || err_clr) err_q <= 1'b0;
        else if (rx_ferr || (rx_push && rx_full)) err_q <= 1'b1;
    end

    uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(tx_rst), .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_fifo_empty)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_rst), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
    );

    uart_bit_clock #(.DIV_W(DIV_W), .PRE(3)) bitclk_i (
        .clk(clk), .rst_n(rst_n), .run(rate_on), .divisor(divisor), .tick(bit_tick)
    );

    uart_tx_shift tx_i (
        .clk(clk), .rst_n(rst_n), .clr(tx_rst), .enable(tx_en), .tick(bit_tick),
        .have_data(!tx_fifo_empty), .data(tx_head), .pop(tx_pop), .txd(txd), .busy(tx_busy)
    );

    uart_rx_frame #(.PW(PER_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_rst), .enable(rx_en), .rxd_s(rxd_s),
        .period(period), .push(rx_push), .data(rx_byte), .frame_err(rx_ferr)
    );

    // Status word assembly.
    always_comb begin
        status_w             = '0;
        status_w[ST_ERR]     = err_q;
        status_w[ST_RXEMPTY] = rx_empty;
        status_w[ST_TXFULL]  = tx_full;
        status_w[ST_TXEMPTY] = tx_fifo_empty && !tx_busy;
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_RXPORT: bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
            OFF_CTRL:   bus_rdata = ctl_q;
            OFF_STAT:   bus_rdata = status_w;
            OFF_RATE:   bus_rdata = baud_q;
            default:    bus_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/fifo_uart_chk.sv
// Property checker for the buffered serial port, bound to the top.
// Assumes the reset and clear bits are driven only by software writes.
module fifo_uart_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        txd,
    input logic        tx_rst,
    input logic        rx_rst,
    input logic        err_clr,
    input logic        rate_on,
    input logic        st_err,
    input logic        st_rxempty,
    input logic        st_txfull,
    input logic        st_txempty
);
    import uart_pkg::*;

    // R10: TX side clear empties the queue and idles the shifter.
    assert_txrst_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (st_txempty && !st_txfull));

    // R10: RX side clear empties the receive queue.
    assert_rxrst_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> st_rxempty);

    // R9: error flag is sticky until cleared.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && !err_clr) |=> st_err);

    // R9: error clear takes effect on the next cycle.
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !st_err);

    // R12: with the rate disabled and no TX clear, the line holds.
    assert_line_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_on && !tx_rst) |=> $stable(txd));

    // R2: misc register reads zero.
    assert_misc_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFF_MISC) |-> (bus_rdata == 32'd0));
endmodule

bind fifo_uart fifo_uart_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .txd(txd), .tx_rst(tx_rst), .rx_rst(rx_rst), .err_clr(err_clr),
    .rate_on(rate_on), .st_err(status_w[16]), .st_rxempty(status_w[20]),
    .st_txfull(status_w[21]), .st_txempty(status_w[22])
);

// File: tb/fifo_uart_tb_top.sv
// Self-checking bench: directed corner cases plus random byte payloads.
module fifo_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int nchk = 0, nerr = 0;
    int per = 9;
    bit done = 0;

    always #5 clk = ~clk;

    fifo_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    function automatic logic [31:0] rate_word(input int div);
        return (32'd1 << 23) | 32'(div);
    endfunction

    function automatic logic stat_bit(input logic [31:0] s, input int b);
        return s[b];
    endfunction

    // Drive one frame on rxd, each bit lasting per clocks.
    task automatic send_frame(input logic [7:0] b, input logic stop);
        logic [9:0] f;
        f = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); rxd = f[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk); rxd = 1'b1;
    endtask

    // Decode one frame from txd at mid-bit.
    task automatic get_frame(output logic [7:0] b, output logic ok);
        logic st, sp;
        @(negedge txd);
        repeat (per / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (per) @(negedge clk);
            b[i] = txd;
        end
        repeat (per) @(negedge clk);
        sp = txd;
        ok = (st == 1'b0) && (sp == 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  exp_q [$];
        logic [7:0]  got;
        logic        ok;
        int          lows;

        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(5'h0C, r); check("R1 status", r, 32'h0050_0000);
        bus_read(5'h08, r); check("R1 control", r, 32'h0);
        bus_read(5'h14, r); check("R1 rate", r, 32'h0);
        bus_read(5'h04, r); check("R1 rx port", r, 32'h0);
        check("R1 txd", {31'd0, txd}, 32'd1);

        // R2: register readback masks
        bus_write(5'h08, 32'hFFFF_FFFF); bus_read(5'h08, r); check("R2 control", r, 32'h01C0_3000);
        bus_write(5'h08, 32'h0);
        bus_write(5'h14, 32'hFFFF_FFFF); bus_read(5'h14, r); check("R2 rate", r, 32'h01FF_FFFF);
        bus_write(5'h10, 32'h1234_5678); bus_read(5'h10, r); check("R2 misc", r, 32'h0);

        // Bring-up: rate, reset pulse, enables
        per = 9;
        bus_write(5'h14, rate_word(2));
        bus_write(5'h08, 32'h01C0_0000);
        bus_write(5'h08, 32'h0);
        bus_write(5'h08, 32'h0000_3000);

        // R3 / R5: random bytes out at two divisors
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                per = 15;
                bus_write(5'h14, rate_word(4));
            end
            exp_q.delete();
            for (int i = 0; i < 5; i++) exp_q.push_back(8'($urandom));
            fork
                begin
                    foreach (exp_q[i]) bus_write(5'h00, {24'd0, exp_q[i]});
                    bus_read(5'h0C, r);
                    check("R5 tx empty low while sending", 32'(stat_bit(r, 22)), 32'd0);
                end
                begin
                    for (int i = 0; i < 5; i++) begin
                        get_frame(got, ok);
                        check("R3 frame shape", 32'(ok), 32'd1);
                        check("R3 byte", 32'(got), 32'(exp_q[i]));
                    end
                end
            join
            repeat (2 * per) @(negedge clk);
            bus_read(5'h0C, r);
            check("R5 tx empty after drain", 32'(stat_bit(r, 22)), 32'd1);
        end
        per = 9;
        bus_write(5'h14, rate_word(2));

        // R4: fill TX queue with transmitter disabled
        bus_write(5'h08, 32'h0000_2000);
        exp_q.delete();
        for (int i = 0; i < 17; i++) exp_q.push_back(8'($urandom));
        foreach (exp_q[i]) bus_write(5'h00, {24'd0, exp_q[i]});
        bus_read(5'h0C, r);
        check("R4 tx full", 32'(stat_bit(r, 21)), 32'd1);
        check("R5 tx empty clear when queued", 32'(stat_bit(r, 22)), 32'd0);
        fork
            bus_write(5'h08, 32'h0000_3000);
            begin
                for (int i = 0; i < 16; i++) begin
                    get_frame(got, ok);
                    check("R4 queued byte", 32'(got), 32'(exp_q[i]));
                end
            end
        join
        lows = 0;
        for (int i = 0; i < 4 * per; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check("R4 17th write dropped", 32'(lows), 32'd0);

        // R12: rate disabled holds the line
        bus_write(5'h14, 32'd2);
        bus_write(5'h00, 32'h5A);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check("R12 no output without rate", 32'(lows), 32'd0);
        bus_read(5'h0C, r);
        check("R12 byte waiting", 32'(stat_bit(r, 22)), 32'd0);
        fork
            bus_write(5'h14, rate_word(2));
            begin get_frame(got, ok); check("R12 byte after enable", 32'(got), 32'h5A); end
        join

        // R6: random receive
        exp_q.delete();
        for (int i = 0; i < 5; i++) exp_q.push_back(8'($urandom));
        foreach (exp_q[i]) send_frame(exp_q[i], 1'b1);
        repeat (4) @(negedge clk);
        bus_read(5'h0C, r);
        check("R6 rx not empty", 32'(stat_bit(r, 20)), 32'd0);
        foreach (exp_q[i]) begin
            bus_read(5'h04, r);
            check("R6 rx byte", r, {24'd0, exp_q[i]});
        end
        bus_read(5'h0C, r);
        check("R6 rx empty after reads", 32'(stat_bit(r, 20)), 32'd1);
        bus_read(5'h04, r);
        check("R6 empty read zero", r, 32'd0);

        // R7: short low glitch
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk); rxd = 1'b1;
        repeat (12 * per) @(negedge clk);
        bus_read(5'h0C, r);
        check("R7 glitch ignored", r & 32'h0011_0000, 32'h0010_0000);

        // R8: framing fault
        send_frame(8'hC3, 1'b0);
        repeat (4 * per) @(negedge clk);
        bus_read(5'h0C, r);
        check("R8 error and no byte", r & 32'h0011_0000, 32'h0011_0000);
        bus_write(5'h08, 32'h0100_3000);
        bus_write(5'h08, 32'h0000_3000);
        bus_read(5'h0C, r);
        check("R8 error cleared", 32'(stat_bit(r, 16)), 32'd0);

        // R9: receive overflow and sticky flag
        exp_q.delete();
        for (int i = 0; i < 17; i++) exp_q.push_back(8'($urandom));
        foreach (exp_q[i]) send_frame(exp_q[i], 1'b1);
        repeat (50) @(negedge clk);
        bus_read(5'h0C, r);
        check("R9 overflow flag", 32'(stat_bit(r, 16)), 32'd1);
        for (int i = 0; i < 16; i++) begin
            bus_read(5'h04, r);
            check("R9 kept byte", r, {24'd0, exp_q[i]});
        end
        bus_read(5'h0C, r);
        check("R9 17th dropped", 32'(stat_bit(r, 20)), 32'd1);
        check("R9 flag still set", 32'(stat_bit(r, 16)), 32'd1);
        bus_write(5'h08, 32'h0100_3000);
        bus_read(5'h0C, r);
        check("R9 flag cleared", 32'(stat_bit(r, 16)), 32'd0);
        bus_write(5'h08, 32'h0000_3000);

        // R10: queue resets
        bus_write(5'h08, 32'h0000_2000);
        for (int i = 0; i < 3; i++) bus_write(5'h00, 32'(i + 1));
        bus_read(5'h0C, r);
        check("R10 tx pending", 32'(stat_bit(r, 22)), 32'd0);
        bus_write(5'h08, 32'h0040_2000);
        bus_write(5'h08, 32'h0000_2000);
        bus_read(5'h0C, r);
        check("R10 tx cleared", 32'(stat_bit(r, 22)), 32'd1);
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        repeat (4) @(negedge clk);
        bus_read(5'h0C, r);
        check("R10 rx pending", 32'(stat_bit(r, 20)), 32'd0);
        bus_write(5'h08, 32'h0080_2000);
        bus_write(5'h08, 32'h0000_2000);
        bus_read(5'h0C, r);
        check("R10 rx cleared", 32'(stat_bit(r, 20)), 32'd1);

        // R11: receiver disabled
        bus_write(5'h08, 32'h0000_1000);
        send_frame(8'h77, 1'b1);
        repeat (4) @(negedge clk);
        bus_read(5'h0C, r);
        check("R11 rx ignored", r & 32'h0011_0000, 32'h0010_0000);

        finish_run();
    end
endmodule